// File: doc/BRIEF.md
# Exception Entry Sequencer

This block takes a 32-bit processor core from normal execution into an exception handler. Four causes can be pending: a bus fault, a non-maskable interrupt (NMI), a software break and an external interrupt. When it is idle, the block picks the cause with the highest priority that is allowed to proceed. It captures the core's context and then spends one cycle writing that context back to the core. In that cycle it writes the return address, the exception status word, the stack pointers, the pushed flags word and a delay-slot clear.

It then reads the handler address from a vector table through a request/valid read port. When that read returns, it loads the new PC, pulses `done`, and acknowledges the cause it took so the core can drop that pending indication. The flags word is "pushed" by a fixed shift rather than through a stack. The NMI-enable bit moves with the architecture version, which the core supplies as an input.

Top module: `exc_entry_seq`

## Requirements
- R1: Simultaneous causes are arbitrated as bus fault, then NMI, then break, then external interrupt. On the done cycle `ack` is one-hot and marks the cause taken: bit 0 bus fault, bit 1 NMI, bit 2 break, bit 3 external interrupt. `ack` is zero on every other cycle.
- R2: An external interrupt is accepted only when `irq_req` is high, flag bit I_BIT (default 4) of `flags_in` is set and `irq_lock` is low.
- R3: An NMI is accepted only when the M flag is set. The M flag is flag bit M_BIT_LEGACY (default 7) when `arch_ver` < VER_SPLIT (default 32), and flag bit M_BIT_MODERN (default 30) otherwise.
- R4: The vector comes from the cause:
  - a break uses `trap_vec`;
  - a bus fault uses `fault_vec`;
  - an external interrupt uses `irq_vec`;
  - an NMI uses 0.
  
  `exs_out` carries the vector in bits 15:8, and its other bits are zero.
- R5: The return address is `pc_in` minus `dslot_in`. It is written with `nrp_we` for an NMI and with `erp_we` for any other cause, never both. `dslot_clr` pulses when `dslot_in` was nonzero.
- R6: When flag bit U_BIT (default 8) is set on entry, `usp_out` takes `sp_in` and `sp_out` takes `ksp_in`, with `usp_we` and `sp_we` high. When that bit is clear, neither of these write enables pulses.
- R7: `flags_out` is `{f[31:30], f[19:0], 10'b0}`. Here `f` is `flags_in`, with the M flag cleared first when the cause is an NMI.
- R8: The read port raises `rd_req` with `rd_addr` = `ebase_in` + 4 × vector. It holds both until `rd_valid`. In the `rd_valid` cycle, `new_pc` equals `rd_data`, and `pc_we` and `done` pulse.
- R9: After reset, `busy` and all write enables are low. Timing of one entry:
  - all context write enables pulse once, in the cycle after acceptance;
  - `busy` stays high from that cycle through the done cycle;
  - no cause is accepted while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bfault_req | input | 1 | Bus fault pending |
| nmi_req | input | 1 | NMI pending |
| brk_req | input | 1 | Software break pending |
| irq_req | input | 1 | External interrupt pending |
| irq_lock | input | 1 | Interrupt lock, blocks external interrupts |
| arch_ver | input | 8 | Architecture version, selects M flag position |
| trap_vec | input | 8 | Break vector |
| fault_vec | input | 8 | Bus fault vector |
| irq_vec | input | 8 | Interrupt controller vector |
| pc_in | input | 32 | Current PC |
| dslot_in | input | 2 | Delay-slot count |
| flags_in | input | 32 | Current flags word |
| sp_in | input | 32 | Current stack pointer |
| ksp_in | input | 32 | Kernel stack pointer |
| ebase_in | input | 32 | Vector table base |
| busy | output | 1 | Entry in progress |
| ret_addr_out | output | 32 | Return address to save |
| erp_we | output | 1 | Write exception return register |
| nrp_we | output | 1 | Write NMI return register |
| exs_out | output | 32 | Exception status value |
| exs_we | output | 1 | Write exception status |
| dslot_clr | output | 1 | Clear delay-slot count |
| usp_out | output | 32 | User stack pointer value |
| usp_we | output | 1 | Write user stack pointer |
| sp_out | output | 32 | New stack pointer |
| sp_we | output | 1 | Write stack pointer |
| flags_out | output | 32 | Pushed flags word |
| flags_we | output | 1 | Write flags word |
| rd_req | output | 1 | Vector table read request |
| rd_addr | output | 32 | Vector table read address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 32 | Read data |
| new_pc | output | 32 | Handler address |
| pc_we | output | 1 | Load PC |
| done | output | 1 | Entry complete |
| ack | output | 4 | One-hot cause acknowledge |

## Verification
A wrong captured cause shows at the ports one cycle after acceptance. It appears as the wrong return-register enable, a wrong vector in `exs_out`, or a missing NMI flag clear. It shows again at `rd_addr` a cycle later and in `ack` on the done cycle. A corrupted context register shows in the single write cycle as a wrong return address, stack value or shifted flags word. A broken state machine shows as `busy` or `rd_req` held or dropped at the wrong cycle, or as a second write pulse. The directed cases place each contested cause against a higher one, each gating flag on both sides, and both M-flag positions.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int XLEN  = 32;
    localparam int VEC_W = 8;
    localparam int DS_W  = 2;
    localparam int NCAUSE = 4;

    typedef enum logic [1:0] {
        CS_BFAULT = 2'd0,
        CS_NMI    = 2'd1,
        CS_BRK    = 2'd2,
        CS_IRQ    = 2'd3
    } cause_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SAVE  = 2'd1,
        ST_FETCH = 2'd2
    } state_e;

    typedef struct packed {
        cause_e            cause;
        logic [VEC_W-1:0]  vec;
        logic [XLEN-1:0]   ret_addr;
        logic              ds_nz;
        logic [XLEN-1:0]   flags;
        logic              swap;
        logic [XLEN-1:0]   usp;
        logic [XLEN-1:0]   ksp;
        logic [XLEN-1:0]   tbl_addr;
    } ctx_t;

    // Fixed-shift push of the flags word: top two kept, low twenty moved up by ten.
    function automatic logic [XLEN-1:0] flags_push(input logic [XLEN-1:0] f);
        return {f[31:30], f[19:0], 10'b0};
    endfunction

    function automatic logic [XLEN-1:0] status_word(input logic [VEC_W-1:0] v);
        return {{(XLEN-VEC_W-8){1'b0}}, v, 8'b0};
    endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
#(
    parameter int I_BIT        = 4,
    parameter int M_BIT_LEGACY = 7,
    parameter int M_BIT_MODERN = 30,
    parameter int VER_SPLIT    = 32
) (
    input  logic            bfault_req,
    input  logic            nmi_req,
    input  logic            brk_req,
    input  logic            irq_req,
    input  logic            irq_lock,
    input  logic [7:0]      arch_ver,
    input  logic [XLEN-1:0] flags_in,
    output logic            take,
    output cause_e          cause,
    output logic [XLEN-1:0] m_mask
);
    localparam logic [7:0] VER_SPLIT_B = 8'(VER_SPLIT);

    logic nmi_ok;
    logic irq_ok;

    always_comb begin
        m_mask = '0;
        if (arch_ver < VER_SPLIT_B) m_mask[M_BIT_LEGACY] = 1'b1;
        else                        m_mask[M_BIT_MODERN] = 1'b1;
    end

    assign nmi_ok = nmi_req && |(flags_in & m_mask);
    assign irq_ok = irq_req && flags_in[I_BIT] && !irq_lock;

    always_comb begin
        take  = 1'b1;
        cause = CS_IRQ;
        if (bfault_req)   cause = CS_BFAULT;
        else if (nmi_ok)  cause = CS_NMI;
        else if (brk_req) cause = CS_BRK;
        else if (irq_ok)  cause = CS_IRQ;
        else              take  = 1'b0;
    end
endmodule

// File: rtl/exc_ctx_calc.sv
module exc_ctx_calc
    import exc_pkg::*;
#(
    parameter int U_BIT = 8
) (
    input  cause_e           cause,
    input  logic [XLEN-1:0]  m_mask,
    input  logic [VEC_W-1:0] trap_vec,
    input  logic [VEC_W-1:0] fault_vec,
    input  logic [VEC_W-1:0] irq_vec,
    input  logic [XLEN-1:0]  pc_in,
    input  logic [DS_W-1:0]  dslot_in,
    input  logic [XLEN-1:0]  flags_in,
    input  logic [XLEN-1:0]  sp_in,
    input  logic [XLEN-1:0]  ksp_in,
    input  logic [XLEN-1:0]  ebase_in,
    output ctx_t             ctx
);
    logic [XLEN-1:0] flags_pre;

    always_comb begin
        ctx.cause = cause;
        unique case (cause)
            CS_BFAULT: ctx.vec = fault_vec;
            CS_NMI:    ctx.vec = '0;
            CS_BRK:    ctx.vec = trap_vec;
            default:   ctx.vec = irq_vec;
        endcase
        ctx.ret_addr = pc_in - {{(XLEN-DS_W){1'b0}}, dslot_in};
        ctx.ds_nz    = |dslot_in;
        flags_pre    = (cause == CS_NMI) ? (flags_in & ~m_mask) : flags_in;
        ctx.flags    = flags_push(flags_pre);
        ctx.swap     = flags_in[U_BIT];
        ctx.usp      = sp_in;
        ctx.ksp      = ksp_in;
        ctx.tbl_addr = ebase_in + {{(XLEN-VEC_W-2){1'b0}}, ctx.vec, 2'b00};
    end
endmodule

// File: rtl/exc_fsm.sv
module exc_fsm
    import exc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   take,
    input  logic   rd_valid,
    output state_e st,
    output logic   load
);
    state_e st_nx;

    assign load = (st == ST_IDLE) && take;

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (take) st_nx = ST_SAVE;
            ST_SAVE:  st_nx = ST_FETCH;
            ST_FETCH: if (rd_valid) st_nx = ST_IDLE;
            default:  st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= st_nx;
    end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_pkg::*;
#(
    parameter int I_BIT        = 4,
    parameter int U_BIT        = 8,
    parameter int M_BIT_LEGACY = 7,
    parameter int M_BIT_MODERN = 30,
    parameter int VER_SPLIT    = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bfault_req,
    input  logic                 nmi_req,
    input  logic                 brk_req,
    input  logic                 irq_req,
    input  logic                 irq_lock,
    input  logic [7:0]           arch_ver,
    input  logic [VEC_W-1:0]     trap_vec,
    input  logic [VEC_W-1:0]     fault_vec,
    input  logic [VEC_W-1:0]     irq_vec,
    input  logic [XLEN-1:0]      pc_in,
    input  logic [DS_W-1:0]      dslot_in,
    input  logic [XLEN-1:0]      flags_in,
    input  logic [XLEN-1:0]      sp_in,
    input  logic [XLEN-1:0]      ksp_in,
    input  logic [XLEN-1:0]      ebase_in,
    output logic                 busy,
    output logic [XLEN-1:0]      ret_addr_out,
    output logic                 erp_we,
    output logic                 nrp_we,
    output logic [XLEN-1:0]      exs_out,
    output logic                 exs_we,
    output logic                 dslot_clr,
    output logic [XLEN-1:0]      usp_out,
    output logic                 usp_we,
    output logic [XLEN-1:0]      sp_out,
    output logic                 sp_we,
    output logic [XLEN-1:0]      flags_out,
    output logic                 flags_we,
    output logic                 rd_req,
    output logic [XLEN-1:0]      rd_addr,
    input  logic                 rd_valid,
    input  logic [XLEN-1:0]      rd_data,
    output logic [XLEN-1:0]      new_pc,
    output logic                 pc_we,
    output logic                 done,
    output logic [NCAUSE-1:0]    ack
);
    logic            take;
    cause_e          cause;
    logic [XLEN-1:0] m_mask;
    ctx_t            ctx_nx;
    ctx_t            ctx_q;
    state_e          st;
    logic            load;
    logic            in_save;
    logic            in_fetch;

    exc_arbiter #(
        .I_BIT(I_BIT), .M_BIT_LEGACY(M_BIT_LEGACY),
        .M_BIT_MODERN(M_BIT_MODERN), .VER_SPLIT(VER_SPLIT)
    ) u_arb (
        .bfault_req(bfault_req), .nmi_req(nmi_req), .brk_req(brk_req),
        .irq_req(irq_req), .irq_lock(irq_lock), .arch_ver(arch_ver),
        .flags_in(flags_in), .take(take), .cause(cause), .m_mask(m_mask)
    );

    exc_ctx_calc #(.U_BIT(U_BIT)) u_ctx (
        .cause(cause), .m_mask(m_mask), .trap_vec(trap_vec),
        .fault_vec(fault_vec), .irq_vec(irq_vec), .pc_in(pc_in),
        .dslot_in(dslot_in), .flags_in(flags_in), .sp_in(sp_in),
        .ksp_in(ksp_in), .ebase_in(ebase_in), .ctx(ctx_nx)
    );

    exc_fsm u_fsm (
        .clk(clk), .rst(rst), .take(take), .rd_valid(rd_valid),
        .st(st), .load(load)
    );

    always_ff @(posedge clk) begin
        if (rst)       ctx_q <= '0;
        else if (load) ctx_q <= ctx_nx;
    end

    assign in_save  = (st == ST_SAVE);
    assign in_fetch = (st == ST_FETCH);
    assign busy     = (st != ST_IDLE);

    // Context write-back, one cycle after acceptance
    assign ret_addr_out = ctx_q.ret_addr;
    assign erp_we       = in_save && (ctx_q.cause != CS_NMI);
    assign nrp_we       = in_save && (ctx_q.cause == CS_NMI);
    assign exs_out      = status_word(ctx_q.vec);
    assign exs_we       = in_save;
    assign dslot_clr    = in_save && ctx_q.ds_nz;
    assign usp_out      = ctx_q.usp;
    assign usp_we       = in_save && ctx_q.swap;
    assign sp_out       = ctx_q.ksp;
    assign sp_we        = in_save && ctx_q.swap;
    assign flags_out    = ctx_q.flags;
    assign flags_we     = in_save;

    // Vector table fetch
    assign rd_req  = in_fetch;
    assign rd_addr = ctx_q.tbl_addr;
    assign done    = in_fetch && rd_valid;
    assign pc_we   = done;
    assign new_pc  = rd_data;

    always_comb begin
        ack = '0;
        if (done) ack[ctx_q.cause] = 1'b1;
    end
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk
    import exc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              erp_we,
    input logic              nrp_we,
    input logic [XLEN-1:0]   exs_out,
    input logic              exs_we,
    input logic              usp_we,
    input logic              sp_we,
    input logic [XLEN-1:0]   flags_out,
    input logic              flags_we,
    input logic              rd_req,
    input logic [XLEN-1:0]   rd_addr,
    input logic              rd_valid,
    input logic              done,
    input logic [NCAUSE-1:0] ack
);
    // R1
    ack_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $countones(ack) == 1);
    // R1
    ack_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> ack == '0);
    // R4
    exs_field_chk: assert property (@(posedge clk) disable iff (rst)
        exs_we |-> (exs_out[31:16] == '0 && exs_out[7:0] == '0));
    // R5
    ret_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({erp_we, nrp_we}));
    // R6
    swap_pair_chk: assert property (@(posedge clk) disable iff (rst)
        sp_we == usp_we);
    // R7
    flags_low_chk: assert property (@(posedge clk) disable iff (rst)
        flags_we |-> flags_out[9:0] == '0);
    // R8
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));
    // R9
    done_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (done || rd_req || exs_we) |-> busy);
    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);
    // R9
    single_write_chk: assert property (@(posedge clk) disable iff (rst)
        exs_we |=> !exs_we);
endmodule

bind exc_entry_seq exc_entry_seq_chk u_chk (.*);

// File: tb/exc_entry_seq_test.sv
module exc_entry_seq_test;
    logic        clk = 0;
    logic        rst = 1;
    logic        bfault_req = 0, nmi_req = 0, brk_req = 0, irq_req = 0, irq_lock = 0;
    logic [7:0]  arch_ver = 8'd40, trap_vec = 0, fault_vec = 0, irq_vec = 0;
    logic [31:0] pc_in = 0, flags_in = 0, sp_in = 0, ksp_in = 0, ebase_in = 0;
    logic [1:0]  dslot_in = 0;
    logic        rd_valid = 0;
    logic [31:0] rd_data = 0;
    logic        busy, erp_we, nrp_we, exs_we, dslot_clr, usp_we, sp_we, flags_we;
    logic        rd_req, pc_we, done;
    logic [31:0] ret_addr_out, exs_out, usp_out, sp_out, flags_out, rd_addr, new_pc;
    logic [3:0]  ack;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    exc_entry_seq uut (.*);

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    task automatic clear_reqs();
        bfault_req = 0; nmi_req = 0; brk_req = 0; irq_req = 0;
    endtask

    // ec: 0 bus fault, 1 NMI, 2 break, 3 irq. Called at a negedge with inputs set.
    task automatic run_entry(input int ec, input int lat, input string tag);
        logic [7:0]  v;
        logic [31:0] f, ef, handler;
        int mpos;
        handler = 32'hC000_0000 ^ pc_in;
        case (ec)
            0: v = fault_vec;
            1: v = 8'h00;
            2: v = trap_vec;
            default: v = irq_vec;
        endcase
        mpos = (arch_ver < 8'd32) ? 7 : 30;
        f = flags_in;
        if (ec == 1) f[mpos] = 1'b0;
        ef = {f[31:30], f[19:0], 10'b0};
        @(negedge clk);   // SAVE cycle
        check({tag, " R9 busy in write cycle"}, {31'b0, busy}, 32'd1);
        check({tag, " R5 erp_we"}, {31'b0, erp_we}, {31'b0, ec != 1});
        check({tag, " R5 nrp_we"}, {31'b0, nrp_we}, {31'b0, ec == 1});
        check({tag, " R5 return address"}, ret_addr_out, pc_in - {30'b0, dslot_in});
        check({tag, " R5 dslot_clr"}, {31'b0, dslot_clr}, {31'b0, dslot_in != 0});
        check({tag, " R4 exs"}, {31'b0, exs_we} ^ exs_out, 32'd1 ^ {16'b0, v, 8'b0});
        check({tag, " R6 usp_we"}, {31'b0, usp_we}, {31'b0, flags_in[8]});
        check({tag, " R6 sp_we"}, {31'b0, sp_we}, {31'b0, flags_in[8]});
        if (flags_in[8]) begin
            check({tag, " R6 usp value"}, usp_out, sp_in);
            check({tag, " R6 sp value"}, sp_out, ksp_in);
        end
        check({tag, " R7 flags_we"}, {31'b0, flags_we}, 32'd1);
        check({tag, " R7 flags value"}, flags_out, ef);
        @(negedge clk);   // FETCH cycle
        check({tag, " R9 single write pulse"}, {31'b0, exs_we | erp_we | nrp_we | flags_we}, 32'd0);
        for (int i = 0; i <= lat; i++) begin
            check({tag, " R8 rd_req held"}, {31'b0, rd_req}, 32'd1);
            check({tag, " R8 rd_addr"}, rd_addr, ebase_in + {22'b0, v, 2'b00});
            check({tag, " R8 no early done"}, {31'b0, done}, 32'd0);
            if (i < lat) @(negedge clk);
        end
        rd_valid = 1; rd_data = handler;
        #1;
        check({tag, " R8 done"}, {31'b0, done}, 32'd1);
        check({tag, " R8 pc_we"}, {31'b0, pc_we}, 32'd1);
        check({tag, " R8 new_pc"}, new_pc, handler);
        check({tag, " R1 ack"}, {28'b0, ack}, 32'd1 << ec);
        check({tag, " R9 busy on done"}, {31'b0, busy}, 32'd1);
        clear_reqs();
        @(negedge clk);
        rd_valid = 0;
        check({tag, " R9 idle after done"}, {31'b0, busy}, 32'd0);
        check({tag, " R1 ack after done"}, {28'b0, ack}, 32'd0);
    endtask

    task automatic expect_reject(input string tag);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check({tag, " no acceptance"}, {30'b0, busy, rd_req}, 32'd0);
            check({tag, " no writes"}, {28'b0, erp_we, nrp_we, exs_we, flags_we}, 32'd0);
        end
        clear_reqs();
        @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R9 reset busy", {31'b0, busy}, 32'd0);
        check("R9 reset enables", {24'b0, erp_we, nrp_we, exs_we, dslot_clr, usp_we, sp_we, flags_we, rd_req}, 32'd0);
        check("R9 reset done/ack", {27'b0, done, ack}, 32'd0);
    endtask

    task automatic t_break_plain();
        trap_vec = 8'h21; pc_in = 32'h0000_1234; dslot_in = 0;
        flags_in = 32'hC00F_0003; ebase_in = 32'h0000_4000; sp_in = 32'h100; ksp_in = 32'h200;
        brk_req = 1;
        run_entry(2, 0, "brk R4 R5 R7");
    endtask

    task automatic t_irq_dslot_user();
        irq_vec = 8'h45; pc_in = 32'h0000_8000; dslot_in = 2;
        flags_in = 32'h0000_0110; sp_in = 32'hAAAA_0000; ksp_in = 32'h5555_0000;
        irq_lock = 0; irq_req = 1;
        run_entry(3, 2, "irq R2 R6");
    endtask

    task automatic t_bfault_wins();
        fault_vec = 8'h0E; trap_vec = 8'h33; irq_vec = 8'h44;
        arch_ver = 8'd40; flags_in = 32'h4000_0010; dslot_in = 1; pc_in = 32'h2000;
        bfault_req = 1; nmi_req = 1; brk_req = 1; irq_req = 1;
        run_entry(0, 1, "all R1 bus fault first");
    endtask

    task automatic t_nmi_modern();
        arch_ver = 8'd40; flags_in = 32'h4000_0190; dslot_in = 0; pc_in = 32'h3000;
        sp_in = 32'h1111; ksp_in = 32'h2222;
        nmi_req = 1; brk_req = 1; irq_req = 1;
        run_entry(1, 0, "nmi R3 R1 modern");
    endtask

    task automatic t_nmi_legacy();
        arch_ver = 8'd10; flags_in = 32'h4000_0080; dslot_in = 3; pc_in = 32'h3010;
        nmi_req = 1;
        run_entry(1, 3, "nmi R3 R7 legacy");
    endtask

    task automatic t_rejects();
        arch_ver = 8'd40; flags_in = 32'h0000_0090;
        nmi_req = 1;
        expect_reject("R3 nmi wrong M position");
        arch_ver = 8'd10; flags_in = 32'h4000_0010;
        nmi_req = 1;
        expect_reject("R3 nmi legacy bit clear");
        flags_in = 32'h0000_0000; irq_lock = 0; irq_req = 1;
        expect_reject("R2 irq I flag clear");
        flags_in = 32'h0000_0010; irq_lock = 1; irq_req = 1;
        expect_reject("R2 irq locked");
        irq_lock = 0;
    endtask

    task automatic t_brk_over_irq();
        arch_ver = 8'd40; flags_in = 32'h0000_0010; trap_vec = 8'hFF; irq_vec = 8'h01;
        ebase_in = 32'hFFFF_FF00; dslot_in = 0; pc_in = 32'h5000;
        brk_req = 1; irq_req = 1;
        run_entry(2, 0, "brk R1 over irq");
    endtask

    initial begin
        t_reset();
        t_break_plain();
        t_irq_dslot_user();
        t_bfault_wins();
        t_nmi_modern();
        t_nmi_legacy();
        t_rejects();
        t_brk_over_irq();
        finish_run();
    end
endmodule